// File: doc/BRIEF.md
# General-Purpose I/O Bank with Interrupt Detection

This block is a sixteen-pin general-purpose I/O bank. A host reaches it through a word-addressed register port with single-cycle writes and combinational reads. Software sets each pin's direction, its normal output value and its alternate-function select. Each pin also has two override values. One drives the pin while the system sleeps. The other drives it when the battery fails.

Every pin input passes through a two-flop synchroniser and then reaches a per-pin detector. Software chooses for each pin between level and edge detection, and between the two polarities. A detection sets a sticky status bit, and software clears that bit by writing a 1 to it. The bank raises one interrupt line whenever a status bit is pending and the mask in force leaves it open. While sleep is active, a separate sleep mask takes the place of the normal mask.

Top module: `gpio_bank`

## Requirements
- R1: Register word indices are 0 interrupt mask, 1 direction, 2 output value, 3 trigger type, 4 edge polarity, 5 level polarity, 6 sleep mask, 7 sleep output, 8 fault output, 9 interrupt status, 10 alternate select and 11 sleep config (bit 0 only, other bits read 0). Indices 12 to 15 are not writable, and indices 13 to 15 read 0. Bit i of every register belongs to pin i, and each writable register reads back the last value written.
- R2: After reset, the interrupt mask and the sleep mask are all ones. Every other register is zero, no pin is driven and irq is low.
- R3: A direction bit of 1 drives the pin (pin_oe=1). A direction bit of 0 leaves it undriven, with pin_oe=0 and pin_out=0. With neither override active, a driven pin outputs its output-value bit, and 0 means low.
- R4: Sleep is active when sleep_mode is high or sleep-config bit 0 is 1. While sleep is active and there is no battery fault, driven pins output their sleep-output bits.
- R5: While batt_fault is high, driven pins output their fault-output bits, whatever the sleep state.
- R6: Index 12 returns the synchronised pin levels, which follow pin_in after two clock edges. Writes to index 12 have no effect.
- R7: A trigger-type bit of 1 selects edge detection. An edge-polarity bit of 0 catches falling edges and 1 catches rising edges. The status bit sets on the third rising clock edge after the pin changes.
- R8: A trigger-type bit of 0 selects level detection. A level-polarity bit of 0 detects a low pin and 1 detects a high pin.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A level condition that still holds sets the bit again on the clock after the clear.
- R10: irq is high exactly when some status bit is 1 and its bit in the mask in force is 0. That mask is the sleep mask while sleep is active and the interrupt mask otherwise.
- R11: alt_sel always equals the alternate-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| pin_in | input | 16 | Pin levels seen at the pads |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Pin output enables |
| alt_sel | output | 16 | Alternate-function select per pin |
| sleep_mode | input | 1 | System sleep indication |
| batt_fault | input | 1 | Battery fault indication |
| irq | output | 1 | Combined bank interrupt |

## Verification
The bench goes after four corner cases.

- **Latency.** It checks that an edge is still invisible two clocks after the pin moves and appears on the third. A design with one synchroniser stage too many or too few fails this check.
- **Clear against a held level.** It clears a level-mode bit whose condition still holds. The bit must read 0 right after the write and 1 one clock later. A design that let detection beat the clear would never show the 0. A design that blocked re-arming would stay at 0.
- **Clear of stable edges.** Edge bits cleared while the pins are stable must stay clear. Writing zeros to the status register must change nothing.
- **Priority and mask swap.** Random output trials cover fault over sleep over normal, with direction gating. Random interrupt trials swap the sleep mask in and out, which exposes a design that applied the wrong mask.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  // Register word index width; the map is fixed at 16 slots.
  localparam int unsigned GPB_AW = 4;

  typedef enum logic [GPB_AW-1:0] {
    RA_MASK  = 4'd0,
    RA_DIR   = 4'd1,
    RA_OUT   = 4'd2,
    RA_TRIG  = 4'd3,
    RA_EPOL  = 4'd4,
    RA_LPOL  = 4'd5,
    RA_SMASK = 4'd6,
    RA_SOUT  = 4'd7,
    RA_FOUT  = 4'd8,
    RA_STAT  = 4'd9,
    RA_ALT   = 4'd10,
    RA_SCONF = 4'd11,
    RA_PINS  = 4'd12
  } gpb_reg_e;

  // One pin's detection: edge compares current against previous sample,
  // level compares current sample against the wanted polarity.
  function automatic logic gpb_hit(input logic edge_sel, input logic epol,
                                   input logic lpol, input logic cur,
                                   input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (edge_sel) return epol ? rise : fall;
    return cur == lpol;
  endfunction

  // One pin's output value: fault beats sleep beats normal.
  function automatic logic gpb_level(input logic fault, input logic sleep,
                                     input logic fval, input logic sval,
                                     input logic nval);
    if (fault) return fval;
    if (sleep) return sval;
    return nval;
  endfunction

endpackage

// File: rtl/gpb_regs.sv
module gpb_regs
  import gpb_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [GPB_AW-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  det,
  input  logic [NPINS-1:0]  pin_lvl,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  trig_q,
  output logic [NPINS-1:0]  epol_q,
  output logic [NPINS-1:0]  lpol_q,
  output logic [NPINS-1:0]  smask_q,
  output logic [NPINS-1:0]  sout_q,
  output logic [NPINS-1:0]  fout_q,
  output logic [NPINS-1:0]  alt_q,
  output logic              sforce_q,
  output logic [NPINS-1:0]  stat_q,
  output logic              stat_clr_wr
);

  logic [NPINS-1:0] stat_clr;

  assign stat_clr_wr = we && (addr == RA_STAT);
  assign stat_clr    = stat_clr_wr ? wdata : '0;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      smask_q  <= '1;
      dir_q    <= '0;
      out_q    <= '0;
      trig_q   <= '0;
      epol_q   <= '0;
      lpol_q   <= '0;
      sout_q   <= '0;
      fout_q   <= '0;
      alt_q    <= '0;
      sforce_q <= 1'b0;
    end else if (we) begin
      case (addr)
        RA_MASK:  mask_q   <= wdata;
        RA_DIR:   dir_q    <= wdata;
        RA_OUT:   out_q    <= wdata;
        RA_TRIG:  trig_q   <= wdata;
        RA_EPOL:  epol_q   <= wdata;
        RA_LPOL:  lpol_q   <= wdata;
        RA_SMASK: smask_q  <= wdata;
        RA_SOUT:  sout_q   <= wdata;
        RA_FOUT:  fout_q   <= wdata;
        RA_ALT:   alt_q    <= wdata;
        RA_SCONF: sforce_q <= wdata[0];
        default:  ;
      endcase
    end
  end

  // Sticky status: new detections accumulate, a clear write wins this cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q | det) & ~stat_clr;
  end

  always_comb begin
    case (addr)
      RA_MASK:  rdata = mask_q;
      RA_DIR:   rdata = dir_q;
      RA_OUT:   rdata = out_q;
      RA_TRIG:  rdata = trig_q;
      RA_EPOL:  rdata = epol_q;
      RA_LPOL:  rdata = lpol_q;
      RA_SMASK: rdata = smask_q;
      RA_SOUT:  rdata = sout_q;
      RA_FOUT:  rdata = fout_q;
      RA_STAT:  rdata = stat_q;
      RA_ALT:   rdata = alt_q;
      RA_SCONF: rdata = {{(NPINS-1){1'b0}}, sforce_q};
      RA_PINS:  rdata = pin_lvl;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpb_detect.sv
module gpb_detect
  import gpb_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] trig,
  input  logic [NPINS-1:0] epol,
  input  logic [NPINS-1:0] lpol,
  output logic [NPINS-1:0] pin_lvl,
  output logic [NPINS-1:0] det
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;
  logic [NPINS-1:0]                  prev_q;

  // Stage 0 takes the raw pins; the highest stage is the usable level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
      prev_q <= sync_q[LAST];
    end
  end

  assign pin_lvl = sync_q[LAST];

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign det[i] = gpb_hit(trig[i], epol[i], lpol[i], pin_lvl[i], prev_q[i]);
  end

endmodule

// File: rtl/gpb_outmux.sv
module gpb_outmux
  import gpb_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             fault,
  input  logic             sleep,
  input  logic [NPINS-1:0] dir,
  input  logic [NPINS-1:0] nval,
  input  logic [NPINS-1:0] sval,
  input  logic [NPINS-1:0] fval,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign pin_out[i] = dir[i] & gpb_level(fault, sleep, fval[i], sval[i], nval[i]);
    assign pin_oe[i]  = dir[i];
  end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpb_pkg::*;
#(
  parameter int NPINS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [GPB_AW-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [NPINS-1:0]  alt_sel,
  input  logic              sleep_mode,
  input  logic              batt_fault,
  output logic              irq
);

  logic [NPINS-1:0] mask_q, dir_q, out_q, trig_q, epol_q, lpol_q;
  logic [NPINS-1:0] smask_q, sout_q, fout_q, alt_q, stat_q;
  logic             sforce_q;
  logic             stat_clr_wr;
  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] det;
  logic             sleep_act;
  logic [NPINS-1:0] eff_mask;
  logic [NPINS-1:0] pend;

  gpb_regs #(.NPINS(NPINS)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .we          (reg_we),
    .addr        (reg_addr),
    .wdata       (reg_wdata),
    .det         (det),
    .pin_lvl     (pin_lvl),
    .rdata       (reg_rdata),
    .mask_q      (mask_q),
    .dir_q       (dir_q),
    .out_q       (out_q),
    .trig_q      (trig_q),
    .epol_q      (epol_q),
    .lpol_q      (lpol_q),
    .smask_q     (smask_q),
    .sout_q      (sout_q),
    .fout_q      (fout_q),
    .alt_q       (alt_q),
    .sforce_q    (sforce_q),
    .stat_q      (stat_q),
    .stat_clr_wr (stat_clr_wr)
  );

  gpb_detect #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) i_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_in  (pin_in),
    .trig    (trig_q),
    .epol    (epol_q),
    .lpol    (lpol_q),
    .pin_lvl (pin_lvl),
    .det     (det)
  );

  assign sleep_act = sleep_mode | sforce_q;

  gpb_outmux #(.NPINS(NPINS)) i_outmux (
    .fault   (batt_fault),
    .sleep   (sleep_act),
    .dir     (dir_q),
    .nval    (out_q),
    .sval    (sout_q),
    .fval    (fout_q),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  assign eff_mask = sleep_act ? smask_q : mask_q;
  assign pend     = stat_q & ~eff_mask;
  assign irq      = |pend;
  assign alt_sel  = alt_q;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int NPINS = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             batt_fault,
  input logic             sleep_act,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] sout,
  input logic [NPINS-1:0] fout,
  input logic [NPINS-1:0] pin_out,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] det,
  input logic             clr_wr,
  input logic [NPINS-1:0] wdata,
  input logic             irq
);

  // R9
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((stat & $past(stat)) == $past(stat)));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((stat & $past(wdata)) == '0));

  // R7 R8
  det_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((stat & $past(det)) == $past(det)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));

  // R5
  fault_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    batt_fault |-> (((pin_out ^ fout) & dir) == '0));

  // R4
  sleep_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!batt_fault && sleep_act) |-> (((pin_out ^ sout) & dir) == '0));

endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .batt_fault (batt_fault),
  .sleep_act  (sleep_act),
  .dir        (dir_q),
  .sout       (sout_q),
  .fout       (fout_q),
  .pin_out    (pin_out),
  .stat       (stat_q),
  .det        (det),
  .clr_wr     (stat_clr_wr),
  .wdata      (reg_wdata),
  .irq        (irq)
);

// File: tb/test_gpio_bank.sv
`timescale 1ns/1ps
module test_gpio_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe, alt_sel;
  logic        sleep_mode = 1'b0;
  logic        batt_fault = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_bank i_gpio_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .alt_sel(alt_sel),
    .sleep_mode(sleep_mode), .batt_fault(batt_fault), .irq(irq)
  );

  function automatic logic [15:0] m_lvl(input logic [15:0] t, input logic [15:0] lp,
                                        input logic [15:0] v);
    return ~t & ~(v ^ lp);
  endfunction

  function automatic logic [15:0] m_edge(input logic [15:0] t, input logic [15:0] ep,
                                         input logic [15:0] a, input logic [15:0] b);
    return t & ((ep & ~a & b) | (~ep & a & ~b));
  endfunction

  function automatic logic [15:0] m_pins(input logic f, input logic s, input logic [15:0] d,
                                         input logic [15:0] o, input logic [15:0] so,
                                         input logic [15:0] fo);
    logic [15:0] v;
    v = f ? fo : (s ? so : o);
    return d & v;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [15:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d, a, b, t, ep, lp, m, sm, c, st, fo, so, o;
    logic sl, fl, sf;
    void'($urandom(32'h1a2b3c4d));

    // R2: reset state
    repeat (3) @(negedge clk);
    rd_chk(4'd0, 16'hFFFF, "R2 mask reset");
    rd_chk(4'd6, 16'hFFFF, "R2 sleep mask reset");
    rd_chk(4'd1, 16'h0000, "R2 dir reset");
    rd_chk(4'd9, 16'h0000, "R2 status reset");
    chk("R2 pin_oe reset", pin_oe, 16'h0000);
    chk("R2 irq reset", {15'd0, irq}, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    // defaults are level-low detection with pins low: all status set, all masked
    repeat (4) @(negedge clk);
    rd_chk(4'd9, 16'hFFFF, "R8 default level-low detect");
    chk("R10 masked status gives no irq", {15'd0, irq}, 16'h0000);

    // R1: readback of every writable register, reserved reads 0
    for (int k = 0; k < 12; k++) begin
      if (k == 9) continue;
      d = 16'($urandom());
      wr(4'(k), d);
      rd_chk(4'(k), (k == 11) ? (d & 16'h0001) : d, "R1 readback");
      if (k == 10) chk("R11 alt_sel", alt_sel, d);
    end
    wr(4'd11, 16'h0000);
    for (int k = 13; k < 16; k++) begin
      wr(4'(k), 16'hFFFF);
      rd_chk(4'(k), 16'h0000, "R1 reserved reads zero");
    end

    // R6: pin state through the synchroniser; writes ignored
    pin_in = 16'hA5C3;
    repeat (2) @(negedge clk);
    rd_chk(4'd12, 16'hA5C3, "R6 pin state after two clocks");
    wr(4'd12, 16'h1234);
    rd_chk(4'd12, 16'hA5C3, "R6 write to pin state ignored");

    // R3 R4 R5 R11: random output trials
    for (int k = 0; k < 40; k++) begin
      d = 16'($urandom()); o = 16'($urandom());
      so = 16'($urandom()); fo = 16'($urandom());
      sf = 1'($urandom()); sl = 1'($urandom()); fl = 1'($urandom());
      wr(4'd1, d); wr(4'd2, o); wr(4'd7, so); wr(4'd8, fo);
      wr(4'd11, {15'd0, sf});
      d = d;
      wr(4'd10, so ^ fo);
      sleep_mode = sl; batt_fault = fl;
      #1;
      chk("R3 pin_oe follows direction", pin_oe, d);
      chk(fl ? "R5 fault output" : ((sl | sf) ? "R4 sleep output" : "R3 normal output"),
          pin_out, m_pins(fl, sl | sf, d, o, so, fo));
      chk("R11 alt_sel", alt_sel, so ^ fo);
    end
    sleep_mode = 1'b0; batt_fault = 1'b0;
    wr(4'd11, 16'h0000);

    // R7 directed: rising edge latency
    wr(4'd3, 16'hFFFF); wr(4'd4, 16'hFFFF); wr(4'd0, 16'h0000);
    pin_in = 16'h0000;
    repeat (4) @(negedge clk);
    wr(4'd9, 16'hFFFF);
    rd_chk(4'd9, 16'h0000, "R7 status clear before edge");
    @(negedge clk);
    pin_in = 16'h0001;
    repeat (2) @(negedge clk);
    rd_chk(4'd9, 16'h0000, "R7 no status two clocks after edge");
    chk("R10 irq low before detect", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    rd_chk(4'd9, 16'h0001, "R7 status on third clock");
    chk("R10 irq on unmasked pending", {15'd0, irq}, 16'h0001);
    // falling polarity
    wr(4'd4, 16'h0000); wr(4'd9, 16'hFFFF);
    pin_in = 16'h0000;
    repeat (3) @(negedge clk);
    rd_chk(4'd9, 16'h0001, "R7 falling edge detect");

    // R9 directed: level re-arms after clear
    wr(4'd3, 16'h0000); wr(4'd5, 16'hFFFF);
    pin_in = 16'h0002;
    repeat (4) @(negedge clk);
    wr(4'd9, 16'hFFFF);
    rd_chk(4'd9, 16'h0000, "R9 clear takes effect");
    @(negedge clk);
    rd_chk(4'd9, 16'h0002, "R9 held level sets again");

    // R7 R8 R9 R10: random interrupt trials
    for (int k = 0; k < 60; k++) begin
      t = 16'($urandom()); ep = 16'($urandom()); lp = 16'($urandom());
      m = 16'($urandom()); sm = 16'($urandom());
      a = 16'($urandom()); b = 16'($urandom()); c = 16'($urandom());
      sl = 1'($urandom());
      wr(4'd3, t); wr(4'd4, ep); wr(4'd5, lp); wr(4'd0, m); wr(4'd6, sm);
      sleep_mode = sl;
      pin_in = a;
      repeat (4) @(negedge clk);
      wr(4'd9, 16'hFFFF);
      @(negedge clk);
      st = m_lvl(t, lp, a);
      rd_chk(4'd9, st, "R8 level status after clear");
      pin_in = b;
      repeat (3) @(negedge clk);
      st = st | m_lvl(t, lp, b) | m_edge(t, ep, a, b);
      rd_chk(4'd9, st, "R7 edge and level status");
      chk("R10 irq with mask in force", {15'd0, irq},
          {15'd0, |(st & ~(sl ? sm : m))});
      wr(4'd9, c);
      @(negedge clk);
      st = (st & ~c) | m_lvl(t, lp, b);
      rd_chk(4'd9, st, "R9 partial clear with stable pins");
      wr(4'd9, 16'h0000);
      rd_chk(4'd9, st, "R9 writing zero keeps status");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule